// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block stops a small 32-bit processor at chosen instruction addresses. A debugger programs it over a word-wide register bus. The bus has a byte address, write data, a write strobe, a read strobe and a read-data return. The unit holds one control word and a build-time number of address comparators. Each comparator holds a word address, an enable and a halfword selector. The control word holds a unit-wide enable, and it also reports how many comparators were built.

On every cycle the unit looks at the instruction fetch address and at two halfword-valid flags that come with it. On the next cycle it raises a one-cycle breakpoint request if three things are true: the unit is enabled, some enabled comparator holds the fetched word address, and that comparator's selector accepts one of the valid halfwords. A write to the control word only takes effect when a key bit is set in the written data. This guards the enable against stray writes.

Top module: `bkpt_unit`

## Requirements
- R1: After a synchronous active-high reset, the unit and comparator enables, every comparator field, `bkpt_req` and `reg_rdata` are all zero.
- R2: The control word is at byte offset 0x0. A write there updates the unit enable (bit 0) only when bit 1 of the write data is 1. Otherwise the write changes nothing.
- R3: Reading the control word returns the unit enable in bit 0, zero in bit 1 (the key), the built comparator count in bits [7:4] (4 by default) and zero in every other bit. Bits [7:4] ignore writes.
- R4: Comparator k is at byte offset 0x8 + 4*k. It stores the halfword selector in bits [31:30], the word address in bits [28:2] and its enable in bit 0. Bits 29 and 1 read as zero and ignore writes.
- R5: A read of offset 0x4, or of any word above the last comparator, returns zero. A write to such an offset changes no register.
- R6: A comparator matches when fetch address bits [28:2] equal its stored address. Fetch address bits [31:29] and [1:0] do not affect the match.
- R7: Selector bit 30 accepts the upper halfword and selector bit 31 accepts the lower halfword. So 2'b01 means upper only, 2'b10 means lower only, 2'b11 means either halfword and 2'b00 never matches. A halfword counts only when its flag in `fetch_hw` is set (bit 1 upper, bit 0 lower). For example, 0x400002D5 traps on the upper halfword of word 0x000002D4.
- R8: `bkpt_req` is raised only for a fetch with `fetch_valid` high, the unit enable set, and at least one enabled comparator that matches.
- R9: `bkpt_req` rises on the clock edge after the qualifying fetch cycle. It stays high for exactly one cycle per qualifying fetch cycle.
- R10: `reg_rdata` carries the addressed word on the clock edge after a cycle with `reg_re` high. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | REG_AW (8) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch byte address |
| fetch_hw | input | 2 | Halfword valid flags, bit 1 upper, bit 0 lower |
| bkpt_req | output | 1 | One-cycle breakpoint request |

## Verification
The bench sends control writes that carry no key. A design that checks the key badly would let such a write switch the unit on or off. It writes all ones to a comparator and reads it back: bits 29 and 1 must come back zero, and the control count must stay fixed, or the read-back gives stray bits. It probes the reserved word at 0x4 and words above the last comparator. An off-by-one in the decoder would return or corrupt a comparator there. The bench also walks all four selector codes against each halfword flag and sets the high and low fetch address bits that must be ignored. A swapped selector bit or a wide address compare would then stop on the wrong halfword or miss a match. A random phase follows, checked every cycle against a behavioural model.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int DATA_W       = 32;
    localparam int CMP_LO       = 2;
    localparam int CMP_HI       = 28;
    localparam int CMP_AW       = CMP_HI - CMP_LO + 1;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_KEY_BIT = 1;
    localparam int CNT_LO       = 4;
    localparam int CNT_W        = 4;
    localparam int CMP_EN_BIT   = 0;
    localparam int FIRST_CMP_IDX = 2;   // word index of comparator 0 (byte 0x8)

    // bit 30 (sel[0]) accepts the upper half, bit 31 (sel[1]) the lower half
    typedef enum logic [1:0] {
        HW_NONE   = 2'b00,
        HW_HIGH   = 2'b01,
        HW_LOW    = 2'b10,
        HW_EITHER = 2'b11
    } hw_sel_e;

    typedef struct packed {
        hw_sel_e            sel;
        logic [CMP_AW-1:0]  addr;
        logic               en;
    } cmp_cfg_t;

    typedef struct packed {
        logic               valid;
        logic [DATA_W-1:0]  addr;
        logic [1:0]         hw;      // [1] upper half valid, [0] lower half valid
    } fetch_t;

    function automatic cmp_cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
        cmp_cfg_t c;
        c.sel  = hw_sel_e'(w[31:30]);
        c.addr = w[CMP_HI:CMP_LO];
        c.en   = w[CMP_EN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input cmp_cfg_t c);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[31:30]          = c.sel;
        w[CMP_HI:CMP_LO]  = c.addr;
        w[CMP_EN_BIT]     = c.en;
        return w;
    endfunction

    function automatic logic half_ok(input hw_sel_e s, input logic [1:0] hw);
        logic [1:0] sb;
        sb = s;
        return (sb[0] & hw[1]) | (sb[1] & hw[0]);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input logic en, input logic [CNT_W-1:0] n);
        logic [DATA_W-1:0] w;
        w                       = '0;
        w[CTRL_EN_BIT]          = en;
        w[CNT_LO +: CNT_W]      = n;
        return w;
    endfunction

endpackage

// File: rtl/bkpt_ctrl_reg.sv
module bkpt_ctrl_reg
    import bkpt_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              global_en,
    output logic [DATA_W-1:0] rd_word
);
    localparam logic [CNT_W-1:0] CNT_VAL = CNT_W'(NUM_CMP);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (wr_sel && wdata[CTRL_KEY_BIT])
            en_q <= wdata[CTRL_EN_BIT];
    end

    assign global_en = en_q;
    assign rd_word   = ctrl_pack(en_q, CNT_VAL);

    // R2: a write without the key leaves the enable untouched
    a_r2_keyless_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !wdata[CTRL_KEY_BIT]) |=> $stable(global_en));

    // R3: key bit never reads back and the count field is fixed
    a_r3_ctrl_readback_shape: assert property (@(posedge clk) disable iff (rst)
        (rd_word[CTRL_KEY_BIT] == 1'b0) && (rd_word[CNT_LO +: CNT_W] == CNT_VAL));

endmodule

// File: rtl/bkpt_comparator.sv
module bkpt_comparator
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  fetch_t            fetch,
    output logic              hit,
    output logic [DATA_W-1:0] rd_word
);
    cmp_cfg_t cfg_q;
    logic     addr_eq;
    logic     half_eq;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_sel)
            cfg_q <= cfg_unpack(wdata);
    end

    assign addr_eq = (fetch.addr[CMP_HI:CMP_LO] == cfg_q.addr);
    assign half_eq = half_ok(cfg_q.sel, fetch.hw);
    assign hit     = fetch.valid && cfg_q.en && addr_eq && half_eq;
    assign rd_word = cfg_pack(cfg_q);

    // R4: a write lands in the fields, reserved bits 29 and 1 stay clear
    a_r4_write_loads_fields: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> (rd_word[31:30] == $past(wdata[31:30])) &&
                   (rd_word[CMP_HI:CMP_LO] == $past(wdata[CMP_HI:CMP_LO])) &&
                   (rd_word[0] == $past(wdata[0])) && (rd_word[29] == 1'b0) && (rd_word[1] == 1'b0));

    // R7: selector 2'b00 never produces a hit
    a_r7_none_sel_silent: assert property (@(posedge clk) disable iff (rst)
        (rd_word[31:30] == 2'b00) |-> !hit);

endmodule

// File: rtl/bkpt_read_mux.sv
module bkpt_read_mux
    import bkpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int IDX_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           re,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DATA_W-1:0]              ctrl_word,
    input  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_words,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] sel_word;
    logic              mapped;

    always_comb begin
        sel_word = '0;
        mapped   = 1'b0;
        if (idx == '0) begin
            sel_word = ctrl_word;
            mapped   = 1'b1;
        end
        for (int k = 0; k < NUM_CMP; k++) begin
            if (idx == IDX_W'(k + FIRST_CMP_IDX)) begin
                sel_word = cmp_words[k];
                mapped   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re && mapped)
            rdata <= sel_word;
        else
            rdata <= '0;
    end

    // R5: reads of holes return zero
    a_r5_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (re && !mapped) |=> (rdata == '0));

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int REG_AW  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    input  logic [1:0]        fetch_hw,
    output logic              bkpt_req
);
    localparam int IDX_W = REG_AW - 2;

    logic [IDX_W-1:0]               word_idx;
    logic                           ctrl_wr;
    logic                           global_en;
    logic [DATA_W-1:0]              ctrl_word;
    logic [NUM_CMP-1:0]             cmp_wr;
    logic [NUM_CMP-1:0]             cmp_hit;
    logic [NUM_CMP-1:0][DATA_W-1:0] cmp_words;
    fetch_t                         fetch;
    logic                           req_q;

    assign word_idx    = reg_addr[REG_AW-1:2];
    assign ctrl_wr     = reg_we && (word_idx == '0);
    assign fetch.valid = fetch_valid;
    assign fetch.addr  = fetch_addr;
    assign fetch.hw    = fetch_hw;

    bkpt_ctrl_reg #(.NUM_CMP(NUM_CMP)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .wr_sel    (ctrl_wr),
        .wdata     (reg_wdata),
        .global_en (global_en),
        .rd_word   (ctrl_word)
    );

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        assign cmp_wr[k] = reg_we && (word_idx == IDX_W'(k + FIRST_CMP_IDX));

        bkpt_comparator cmp_i (
            .clk     (clk),
            .rst     (rst),
            .wr_sel  (cmp_wr[k]),
            .wdata   (reg_wdata),
            .fetch   (fetch),
            .hit     (cmp_hit[k]),
            .rd_word (cmp_words[k])
        );
    end

    bkpt_read_mux #(.NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) rmux_i (
        .clk       (clk),
        .rst       (rst),
        .re        (reg_re),
        .idx       (word_idx),
        .ctrl_word (ctrl_word),
        .cmp_words (cmp_words),
        .rdata     (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= global_en && (|cmp_hit);
    end

    assign bkpt_req = req_q;

    // R8: a request needs the unit enable in the fetch cycle
    a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        bkpt_req |-> $past(global_en));

    // R9: a request follows a valid fetch by one edge
    a_r9_req_after_valid: assert property (@(posedge clk) disable iff (rst)
        bkpt_req |-> $past(fetch_valid));

    // R10: no read strobe, no read data
    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_re) |-> (reg_rdata == '0));

endmodule

// File: tb/bkpt_unit_tb_top.sv
module bkpt_unit_tb_top;

    localparam int NC = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [31:0]   r_wdata = '0;
    logic          r_we = 1'b0;
    logic          r_re = 1'b0;
    logic [31:0]   rdata;
    logic          f_valid = 1'b0;
    logic [31:0]   f_addr = '0;
    logic [1:0]    f_hw = '0;
    logic          req;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    bit armed = 1'b0;

    // reference model state
    logic [31:0] m_cmp [NC];
    logic        m_en;
    logic        exp_req;
    logic [31:0] exp_rdata;

    always #10 clk = ~clk;   // 50 MHz

    bkpt_unit #(.NUM_CMP(NC), .REG_AW(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (r_addr),
        .reg_wdata   (r_wdata),
        .reg_we      (r_we),
        .reg_re      (r_re),
        .reg_rdata   (rdata),
        .fetch_valid (f_valid),
        .fetch_addr  (f_addr),
        .fetch_hw    (f_hw),
        .bkpt_req    (req)
    );

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int wi;
        wi = int'(a) / 4;
        if (wi == 0)
            return {24'h0, 4'(NC), 3'b000, m_en};
        if (wi >= 2 && wi < NC + 2)
            return m_cmp[wi-2];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_en = 1'b0;
            for (int i = 0; i < NC; i++) m_cmp[i] = 32'h0;
            exp_req   = 1'b0;
            exp_rdata = 32'h0;
            armed     = 1'b1;
        end else begin
            logic hitv;
            int   wi;
            hitv = 1'b0;
            for (int i = 0; i < NC; i++) begin
                if (m_cmp[i][0] && (m_cmp[i][28:2] == f_addr[28:2]) &&
                    ((m_cmp[i][30] && f_hw[1]) || (m_cmp[i][31] && f_hw[0])))
                    hitv = 1'b1;
            end
            exp_req   = f_valid && m_en && hitv;
            exp_rdata = r_re ? model_read(r_addr) : 32'h0;
            if (r_we) begin
                wi = int'(r_addr) / 4;
                if (wi == 0 && r_wdata[1])
                    m_en = r_wdata[0];
                else if (wi >= 2 && wi < NC + 2)
                    m_cmp[wi-2] = r_wdata & 32'hDFFF_FFFD;
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !done) begin
            total++;
            if (req !== exp_req) begin
                bad++;
                $display("FAIL R8 model req at cycle %0d: actual=%0b expected=%0b", cyc, req, exp_req);
            end
            total++;
            if (rdata !== exp_rdata) begin
                bad++;
                $display("FAIL R10 model rdata at cycle %0d: actual=%08h expected=%08h", cyc, rdata, exp_rdata);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        r_addr = a; r_wdata = d; r_we = 1'b1;
        @(negedge clk);
        r_we = 1'b0;
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        r_addr = a; r_re = 1'b1;
        @(negedge clk);
        r_re = 1'b0;
        chk(tag, rdata, e);
    endtask

    task automatic fetch_expect(input logic [31:0] a, input logic [1:0] hw, input logic e, input string tag);
        @(negedge clk);
        f_valid = 1'b1; f_addr = a; f_hw = hw;
        @(negedge clk);
        f_valid = 1'b0;
        chk(tag, {31'h0, req}, {31'h0, e});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1 and R3 reset state
        chk("R1 req after reset", {31'h0, req}, 32'h0);
        chk("R1 rdata after reset", rdata, 32'h0);
        rd_expect(8'h00, 32'h0000_0040, "R3 control count at reset");
        rd_expect(8'h08, 32'h0, "R1 comparator 0 cleared");
        rd_expect(8'h14, 32'h0, "R1 comparator 3 cleared");

        // R2 key handling
        wr(8'h00, 32'h0000_0001);
        rd_expect(8'h00, 32'h0000_0040, "R2 keyless enable dropped");
        wr(8'h00, 32'h0000_0003);
        rd_expect(8'h00, 32'h0000_0041, "R2 keyed enable taken");
        wr(8'h00, 32'hFFFF_FF00);
        rd_expect(8'h00, 32'h0000_0041, "R2 keyless disable dropped");
        wr(8'h00, 32'hFFFF_FFFF);
        rd_expect(8'h00, 32'h0000_0041, "R3 count and key read-only");

        // R4 comparator layout
        wr(8'h08, 32'h4000_02D5);
        rd_expect(8'h08, 32'h4000_02D5, "R4 comparator 0 readback");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_expect(8'h0C, 32'hDFFF_FFFD, "R4 reserved bits read zero");

        // R5 holes
        wr(8'h04, 32'hFFFF_FFFF);
        rd_expect(8'h04, 32'h0, "R5 reserved word 0x4");
        wr(8'h18, 32'hFFFF_FFFF);
        rd_expect(8'h18, 32'h0, "R5 above last comparator");
        rd_expect(8'hFC, 32'h0, "R5 top of space");
        rd_expect(8'h08, 32'h4000_02D5, "R5 hole write left comparator 0");

        // R7 halfword selection on comparator 0 (upper only)
        wr(8'h0C, 32'h0);
        fetch_expect(32'h0000_02D4, 2'b11, 1'b1, "R7 upper sel, both halves");
        fetch_expect(32'h0000_02D4, 2'b01, 1'b0, "R7 upper sel, lower only");
        fetch_expect(32'h0000_02D4, 2'b10, 1'b1, "R7 upper sel, upper only");
        // R6 ignored address bits
        fetch_expect(32'hE000_02D6, 2'b10, 1'b1, "R6 high and low bits ignored");
        fetch_expect(32'h0000_02D8, 2'b11, 1'b0, "R6 next word no match");
        // lower-only and none selectors
        wr(8'h10, 32'h8000_0101);
        fetch_expect(32'h0000_0100, 2'b01, 1'b1, "R7 lower sel, lower half");
        fetch_expect(32'h0000_0100, 2'b10, 1'b0, "R7 lower sel, upper half");
        wr(8'h14, 32'h0000_0201);
        fetch_expect(32'h0000_0200, 2'b11, 1'b0, "R7 none sel never hits");
        wr(8'h14, 32'hC000_0200);
        fetch_expect(32'h0000_0200, 2'b11, 1'b0, "R8 comparator disabled");
        wr(8'h14, 32'hC000_0201);
        fetch_expect(32'h0000_0200, 2'b01, 1'b1, "R7 either sel, lower half");

        // R8 unit enable and valid
        wr(8'h00, 32'h0000_0002);
        fetch_expect(32'h0000_02D4, 2'b11, 1'b0, "R8 unit disabled");
        wr(8'h00, 32'h0000_0003);
        @(negedge clk);
        f_valid = 1'b0; f_addr = 32'h0000_02D4; f_hw = 2'b11;
        @(negedge clk);
        chk("R8 no valid no req", {31'h0, req}, 32'h0);

        // R9 timing: two back-to-back qualifying fetches
        f_valid = 1'b1;
        chk("R9 not same cycle", {31'h0, req}, 32'h0);
        @(negedge clk);
        chk("R9 first pulse", {31'h0, req}, 32'h1);
        @(negedge clk);
        f_valid = 1'b0;
        chk("R9 second pulse", {31'h0, req}, 32'h1);
        @(negedge clk);
        chk("R9 drops after fetch", {31'h0, req}, 32'h0);

        // R10 read data idles to zero
        rd_expect(8'h08, 32'h4000_02D5, "R10 read returns word");
        @(negedge clk);
        chk("R10 rdata zero without strobe", rdata, 32'h0);

        // random phase checked by the model
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            r_we    = ($urandom % 4) == 0;
            r_re    = ($urandom % 2) == 0;
            r_addr  = AW'(($urandom % 20) * 4);
            r_wdata = $urandom & 32'hE000_003F;
            f_valid = ($urandom % 4) != 0;
            f_addr  = $urandom & 32'hE000_003F;
            f_hw    = 2'($urandom);
        end
        @(negedge clk);
        r_we = 1'b0; r_re = 1'b0; f_valid = 1'b0;

        // R1 reset mid-run
        wr(8'h08, 32'hC000_0011);
        do_reset();
        rd_expect(8'h08, 32'h0, "R1 comparator cleared by reset");
        rd_expect(8'h00, 32'h0000_0040, "R1 enable cleared by reset");

        @(negedge clk);
        finish_run();
    end

endmodule